// File: doc/BRIEF.md
# Cache Way Locking Controller

This block holds the tag, valid, lock and recency state of a set-associative first-level cache, and it decides which way each request uses. Every request names a set, a tag and a two-bit level selector. It is either a normal access or a touch-and-lock. On a normal access the block reports a hit, or it picks a replacement victim from the unlocked ways of the set. On a touch-and-lock the block pins the addressed line in place. If the line is not present, the block first allocates it. Locked ways are never offered as replacement victims.

Two conditions are recorded in sticky status bits that software reads. The first is an overlock: a lock request arrives at a set whose ways are all pinned. The second is an unable-to-lock: a lock request has to be discarded. Neither condition produces a fault or an error response. A flash-clear strobe releases every lock in the array in a single cycle and needs no address. Requests aimed at the second cache level only pass through this block: they are forwarded unchanged and leave the local state alone. The line data, the memory refill path and the second level itself are outside this block.

Top module: `way_lock_ctrl`

## Requirements
- R1: Each way of each set has its own lock bit. Locking one line leaves every other way, in the same set or in another set, free for normal replacement.
- R2: `req_target` encoding: 0 acts on this cache. 1 is copied to `fwd_valid`/`fwd_lock`/`fwd_index`/`fwd_tag` one cycle later and changes no local state. 2 and 3 are no-ops, and a lock request with 2 or 3 sets the unable-to-lock status bit.
- R3: A lock request to this cache is always carried out. On a hit the existing way is locked (`rsp_hit`, `rsp_way`). On a miss with an unlocked way available, the line is allocated into the victim and locked (`rsp_fill`).
- R4: A lock request that misses in a set with all ways locked evicts the least recently used way, clearing both its valid and lock bits (`rsp_drop`=1, `rsp_fill`=0, `rsp_way`=that way). It also sets the overlock status bit and does not install the new line.
- R5: `sts_ovl` and `sts_utl` stay set until cleared by writing 1 to `sts_clr` (bit 0 clears overlock, bit 1 clears unable-to-lock). A set in the same cycle wins over a clear.
- R6: `flash_clr` releases all lock bits in one cycle. A lock request presented in the same cycle is handled after the release, and its own lock survives.
- R7: On a normal miss the victim is the lowest-numbered invalid unlocked way if one exists, otherwise the least recently used unlocked way. Hits and fills make a way most recently used. If all ways are locked, a normal miss allocates nothing (`rsp_valid` with no hit, fill or drop).
- R8: Response and status outputs register the request one cycle after it is presented. `rsp_drop` accompanies a fill that displaces a valid line.
- R9: After reset all lines are invalid and unlocked, both status bits are 0, and the recency order within each set ranks a higher way index as older.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_lock | input | 1 | 1 = touch-and-lock, 0 = normal access |
| req_target | input | 2 | Cache level selector |
| req_index | input | IDX_W | Set index |
| req_tag | input | TAG_W | Line tag |
| flash_clr | input | 1 | Release all locks |
| sts_clr | input | 2 | Write-1-to-clear for status bits |
| rsp_valid | output | 1 | Local response present |
| rsp_hit | output | 1 | Tag found in set |
| rsp_fill | output | 1 | Line allocated into `rsp_way` |
| rsp_drop | output | 1 | Valid line in `rsp_way` displaced |
| rsp_way | output | WAY_W | Way used by the response |
| fwd_valid | output | 1 | Request forwarded to second level |
| fwd_lock | output | 1 | Forwarded request kind |
| fwd_index | output | IDX_W | Forwarded set index |
| fwd_tag | output | TAG_W | Forwarded tag |
| sts_ovl | output | 1 | Sticky overlock status |
| sts_utl | output | 1 | Sticky unable-to-lock status |

## Verification
The assertions check the following on every cycle: every lock request to this cache is answered, each status bit rises only after its own cause and holds until a write-1 clear, a lone flash clear empties the whole lock array, and a response is never both a hit and a fill. Which way is chosen depends on the recency history of the set, and that history cannot be expressed as a simple property. So the bench's per-set model is what shows victim order, overlock eviction of the oldest way, the same-cycle flash-and-lock ordering, and the isolation of forwarded requests from local state.

// File: rtl/wlc_pkg.sv
// Shared constants for the way locking controller.
// Assumes a two-bit level selector and a two-bit status clear vector.
package wlc_pkg;
    localparam logic [1:0] TGT_L1 = 2'd0;
    localparam logic [1:0] TGT_L2 = 2'd1;
    localparam int CLR_OVL = 0;
    localparam int CLR_UTL = 1;
endpackage

// File: rtl/wlc_tag_match.sv
// Parallel tag compare across the ways of one set.
// Assumes at most one valid way holds a given tag; the lowest match wins.
module wlc_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]       valid,
    input  logic [WAYS*TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]      tag,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way
);
    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = valid[w] && (tags[w*TAG_W +: TAG_W] == tag);
    end

    // Encode the lowest matching way.
    always_comb begin
        hit     = |eq;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (eq[w]) hit_way = WAY_W'(w);
    end
endmodule

// File: rtl/wlc_victim_sel.sv
// Victim choice for one set: first invalid unlocked way, else the oldest
// unlocked way; also reports the oldest way overall for overlock eviction.
// Assumes ages form a permutation, with a larger age meaning older.
module wlc_victim_sel #(
    parameter int WAYS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]       valid,
    input  logic [WAYS-1:0]       lock,
    input  logic [WAYS*WAY_W-1:0] ages,
    output logic                  free_any,
    output logic [WAY_W-1:0]      free_way,
    output logic [WAY_W-1:0]      lru_way
);
    logic             inv_any;
    logic [WAY_W-1:0] inv_way;
    logic [WAY_W-1:0] old_way;
    logic [WAY_W-1:0] old_age;
    logic [WAY_W-1:0] all_age;

    // Scan the set for an empty slot, the oldest unlocked way and the oldest way.
    always_comb begin
        inv_any = 1'b0;
        inv_way = '0;
        old_way = '0;
        old_age = '0;
        lru_way = '0;
        all_age = '0;
        free_any = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid[w] && !lock[w] && !inv_any) begin
                inv_any = 1'b1;
                inv_way = WAY_W'(w);
            end
            if (!lock[w] && (!free_any || ages[w*WAY_W +: WAY_W] > old_age)) begin
                free_any = 1'b1;
                old_way  = WAY_W'(w);
                old_age  = ages[w*WAY_W +: WAY_W];
            end
            if (w == 0 || ages[w*WAY_W +: WAY_W] > all_age) begin
                lru_way = WAY_W'(w);
                all_age = ages[w*WAY_W +: WAY_W];
            end
        end
        free_way = inv_any ? inv_way : old_way;
    end
endmodule

// File: rtl/wlc_age_upd.sv
// Recency rank update for one set: the touched way becomes age 0, and the
// ways younger than it age by one. Assumes the input ages are a permutation.
module wlc_age_upd #(
    parameter int WAYS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS*WAY_W-1:0] ages_in,
    input  logic                  touch,
    input  logic [WAY_W-1:0]      way,
    output logic [WAYS*WAY_W-1:0] ages_out
);
    logic [WAY_W-1:0] ref_age;

    assign ref_age = ages_in[int'(way)*WAY_W +: WAY_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_age
        // Compute the new rank of one way.
        always_comb begin
            ages_out[w*WAY_W +: WAY_W] = ages_in[w*WAY_W +: WAY_W];
            if (touch) begin
                if (way == WAY_W'(w))
                    ages_out[w*WAY_W +: WAY_W] = '0;
                else if (ages_in[w*WAY_W +: WAY_W] < ref_age)
                    ages_out[w*WAY_W +: WAY_W] = ages_in[w*WAY_W +: WAY_W] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/way_lock_ctrl.sv
// Way locking controller: keeps the valid, tag, lock and recency state of a
// set-associative cache, and serves normal and touch-and-lock requests.
// Also handles overlock eviction, sticky status and flash release of all locks.
// Assumes one request per cycle; the data array lives elsewhere.
module way_lock_ctrl
    import wlc_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_lock,
    input  logic [1:0]       req_target,
    input  logic [IDX_W-1:0] req_index,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             flash_clr,
    input  logic [1:0]       sts_clr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_fill,
    output logic             rsp_drop,
    output logic [WAY_W-1:0] rsp_way,
    output logic             fwd_valid,
    output logic             fwd_lock,
    output logic [IDX_W-1:0] fwd_index,
    output logic [TAG_W-1:0] fwd_tag,
    output logic             sts_ovl,
    output logic             sts_utl
);
    logic [WAYS-1:0]       valid_q [SETS];
    logic [WAYS-1:0]       lock_q  [SETS];
    logic [WAYS*TAG_W-1:0] tag_q   [SETS];
    logic [WAYS*WAY_W-1:0] age_q   [SETS];

    logic [WAYS-1:0]       cur_valid, lock_eff, valid_nx, lock_nx;
    logic [WAYS*TAG_W-1:0] cur_tags, tag_nx;
    logic [WAYS*WAY_W-1:0] cur_ages, age_nx;
    logic                  hit, free_any, touch, go_l1;
    logic [WAY_W-1:0]      hit_way, free_way, lru_way, touch_way;
    logic                  d_hit, d_fill, d_drop, ovl_set, utl_set;
    logic [WAY_W-1:0]      d_way;
    logic [SETS*WAYS-1:0]  lock_all;

    assign cur_valid = valid_q[req_index];
    assign cur_tags  = tag_q[req_index];
    assign cur_ages  = age_q[req_index];
    assign lock_eff  = flash_clr ? '0 : lock_q[req_index];
    assign go_l1     = req_valid && (req_target == TGT_L1);
    assign utl_set   = req_valid && req_lock && (req_target > TGT_L2);

    for (genvar s = 0; s < SETS; s++) begin : g_flat
        assign lock_all[s*WAYS +: WAYS] = lock_q[s];
    end

    wlc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .valid(cur_valid), .tags(cur_tags), .tag(req_tag),
        .hit(hit), .hit_way(hit_way)
    );

    wlc_victim_sel #(.WAYS(WAYS)) u_vsel (
        .valid(cur_valid), .lock(lock_eff), .ages(cur_ages),
        .free_any(free_any), .free_way(free_way), .lru_way(lru_way)
    );

    wlc_age_upd #(.WAYS(WAYS)) u_age (
        .ages_in(cur_ages), .touch(touch), .way(touch_way), .ages_out(age_nx)
    );

    // Decide hit, fill or overlock eviction for a request to this cache.
    always_comb begin
        valid_nx  = cur_valid;
        lock_nx   = lock_eff;
        tag_nx    = cur_tags;
        touch     = 1'b0;
        touch_way = '0;
        d_hit     = 1'b0;
        d_fill    = 1'b0;
        d_drop    = 1'b0;
        d_way     = '0;
        ovl_set   = 1'b0;
        if (go_l1) begin
            if (hit) begin
                d_hit     = 1'b1;
                d_way     = hit_way;
                touch     = 1'b1;
                touch_way = hit_way;
                if (req_lock) lock_nx[hit_way] = 1'b1;
            end else if (free_any) begin
                d_fill    = 1'b1;
                d_way     = free_way;
                d_drop    = cur_valid[free_way];
                touch     = 1'b1;
                touch_way = free_way;
                valid_nx[free_way] = 1'b1;
                lock_nx[free_way]  = req_lock;
                tag_nx[int'(free_way)*TAG_W +: TAG_W] = req_tag;
            end else if (req_lock) begin
                d_drop  = 1'b1;
                d_way   = lru_way;
                ovl_set = 1'b1;
                valid_nx[lru_way] = 1'b0;
                lock_nx[lru_way]  = 1'b0;
            end
        end
    end

    // Hold the per-line state; flash release first, then the request's update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                lock_q[s]  <= '0;
                tag_q[s]   <= '0;
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w*WAY_W +: WAY_W] <= WAY_W'(w);
            end
        end else begin
            if (flash_clr)
                for (int s = 0; s < SETS; s++) lock_q[s] <= '0;
            if (go_l1) begin
                valid_q[req_index] <= valid_nx;
                lock_q[req_index]  <= lock_nx;
                tag_q[req_index]   <= tag_nx;
                age_q[req_index]   <= age_nx;
            end
        end
    end

    // Register the local response and the forwarded request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fill  <= 1'b0;
            rsp_drop  <= 1'b0;
            rsp_way   <= '0;
            fwd_valid <= 1'b0;
            fwd_lock  <= 1'b0;
            fwd_index <= '0;
            fwd_tag   <= '0;
        end else begin
            rsp_valid <= go_l1;
            rsp_hit   <= d_hit;
            rsp_fill  <= d_fill;
            rsp_drop  <= d_drop;
            rsp_way   <= d_way;
            fwd_valid <= req_valid && (req_target == TGT_L2);
            fwd_lock  <= req_lock;
            fwd_index <= req_index;
            fwd_tag   <= req_tag;
        end
    end

    // Sticky status with write-1-to-clear; a new event beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_ovl <= 1'b0;
            sts_utl <= 1'b0;
        end else begin
            sts_ovl <= ovl_set || (sts_ovl && !sts_clr[CLR_OVL]);
            sts_utl <= utl_set || (sts_utl && !sts_clr[CLR_UTL]);
        end
    end

    a_r3_lock_served: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_lock && req_target == TGT_L1 |=> rsp_valid && (rsp_hit || rsp_fill || rsp_drop));
    a_r4_ovl_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_ovl) |-> $past(req_valid && req_lock && req_target == TGT_L1) && rsp_drop && !rsp_fill);
    a_r2_utl_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_utl) |-> $past(req_valid && req_lock && req_target > TGT_L2));
    a_r5_ovl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sts_ovl && !sts_clr[CLR_OVL] |=> sts_ovl);
    a_r5_utl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sts_utl && !sts_clr[CLR_UTL] |=> sts_utl);
    a_r6_flash_all: assert property (@(posedge clk) disable iff (!rst_n)
        flash_clr && !(req_valid && req_lock) |=> lock_all == '0);
    a_r7_hit_or_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_fill}));
    a_r2_fwd_local: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> !rsp_valid);
endmodule

// File: tb/way_lock_ctrl_test.sv
// Self-checking bench: per-set reference model with timestamps for recency.
module way_lock_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int SETS = 4, WAYS = 4, TAG_W = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_lock = 0, flash_clr = 0;
    logic [1:0] req_target = 0, sts_clr = 0;
    logic [1:0] req_index = 0;
    logic [TAG_W-1:0] req_tag = 0;
    logic rsp_valid, rsp_hit, rsp_fill, rsp_drop, fwd_valid, fwd_lock, sts_ovl, sts_utl;
    logic [1:0] rsp_way, fwd_index;
    logic [TAG_W-1:0] fwd_tag;

    int checks = 0, fails = 0;
    bit done = 0;
    bit m_valid [SETS][WAYS];
    bit m_lock  [SETS][WAYS];
    int m_tag   [SETS][WAYS];
    int m_stamp [SETS][WAYS];
    int now = 0;
    bit m_ovl = 0, m_utl = 0;
    int unsigned seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    way_lock_ctrl #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lock(req_lock),
        .req_target(req_target), .req_index(req_index), .req_tag(req_tag),
        .flash_clr(flash_clr), .sts_clr(sts_clr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_fill(rsp_fill), .rsp_drop(rsp_drop), .rsp_way(rsp_way),
        .fwd_valid(fwd_valid), .fwd_lock(fwd_lock), .fwd_index(fwd_index),
        .fwd_tag(fwd_tag), .sts_ovl(sts_ovl), .sts_utl(sts_utl)
    );

    task automatic check(input string rq, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", rq, got, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    function automatic void model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_lock[s][w] = 0; m_tag[s][w] = 0;
                m_stamp[s][w] = -w;
            end
        m_ovl = 0; m_utl = 0; now = 0;
    endfunction

    // One request: drive at a falling edge, compare at the next falling edge.
    task automatic op(input bit v, input bit lk, input logic [1:0] tg, input int idx,
                      input int tag, input bit fl, input logic [1:0] clr, input string rq);
        bit e_rv = 0, e_hit = 0, e_fill = 0, e_drop = 0, e_fwd = 0;
        int e_way = 0, hw = -1, vw = -1;
        logic [31:0] got, exp;
        @(negedge clk);
        req_valid = v; req_lock = lk; req_target = tg; req_index = 2'(idx);
        req_tag = TAG_W'(tag); flash_clr = fl; sts_clr = clr;
        if (fl)
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) m_lock[s][w] = 0;
        if (v && tg == 0) begin
            e_rv = 1;
            for (int w = 0; w < WAYS; w++)
                if (hw < 0 && m_valid[idx][w] && m_tag[idx][w] == tag) hw = w;
            if (hw >= 0) begin
                e_hit = 1; e_way = hw; m_stamp[idx][hw] = ++now;
                if (lk) m_lock[idx][hw] = 1;
            end else begin
                for (int w = 0; w < WAYS; w++)
                    if (vw < 0 && !m_valid[idx][w] && !m_lock[idx][w]) vw = w;
                if (vw < 0)
                    for (int w = 0; w < WAYS; w++)
                        if (!m_lock[idx][w] && (vw < 0 || m_stamp[idx][w] < m_stamp[idx][vw])) vw = w;
                if (vw >= 0) begin
                    e_fill = 1; e_way = vw; e_drop = m_valid[idx][vw];
                    m_valid[idx][vw] = 1; m_lock[idx][vw] = lk; m_tag[idx][vw] = tag;
                    m_stamp[idx][vw] = ++now;
                end else if (lk) begin
                    e_way = 0;
                    for (int w = 1; w < WAYS; w++)
                        if (m_stamp[idx][w] < m_stamp[idx][e_way]) e_way = w;
                    e_drop = 1; m_valid[idx][e_way] = 0; m_lock[idx][e_way] = 0;
                end
            end
        end
        e_fwd = v && tg == 1;
        m_ovl = (v && lk && tg == 0 && e_drop && !e_fill) || (m_ovl && !clr[0]);
        m_utl = (v && lk && tg > 1) || (m_utl && !clr[1]);
        @(negedge clk);
        req_valid = 0; req_lock = 0; flash_clr = 0; sts_clr = 0;
        exp = {16'd0, e_rv, e_hit, e_fill, e_drop,
               (e_hit | e_fill | e_drop) ? 2'(e_way) : 2'd0,
               e_fwd, e_fwd ? lk : 1'b0, e_fwd ? 2'(idx) : 2'd0,
               e_fwd ? TAG_W'(tag) : TAG_W'(0), m_ovl, m_utl};
        got = {16'd0, rsp_valid, rsp_hit, rsp_fill, rsp_drop,
               (rsp_hit | rsp_fill | rsp_drop) ? rsp_way : 2'd0,
               fwd_valid, fwd_valid ? fwd_lock : 1'b0, fwd_valid ? fwd_index : 2'd0,
               fwd_valid ? fwd_tag : TAG_W'(0), sts_ovl, sts_utl};
        check(rq, got, exp);
    endtask

    function automatic int rnd(input int n);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 8) % n);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R8: got timeout expected completion");
        summary();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9: reset state of outputs and status
        check("R9 reset", {28'd0, rsp_valid, fwd_valid, sts_ovl, sts_utl}, 32'd0);
        // R9 R7: first misses fill ways in index order, then the oldest is replaced
        for (int s = 0; s < SETS; s++)
            for (int t = 0; t < WAYS + 2; t++) op(1, 0, 0, s, t + 1, 0, 0, "R7 fill");
        for (int s = 0; s < SETS; s++) op(1, 0, 0, s, 3, 0, 0, "R7 hit");
        // R3 R1: lock one line per set by hit and one by miss, then churn
        for (int s = 0; s < SETS; s++) begin
            op(1, 1, 0, s, 3, 0, 0, "R3 lock hit");
            op(1, 1, 0, s, 20 + s, 0, 0, "R3 lock miss");
            for (int t = 0; t < 6; t++) op(1, 0, 0, s, 30 + t, 0, 0, "R1 avoid locked");
            op(1, 0, 0, s, 3, 0, 0, "R1 locked kept");
        end
        // R4: lock all ways of set 1 then overlock; R5 sticky and clear
        for (int t = 0; t < WAYS; t++) op(1, 1, 0, 1, 40 + t, 0, 0, "R3 lock all");
        op(1, 0, 0, 1, 50, 0, 0, "R7 no alloc");
        op(1, 1, 0, 1, 51, 0, 0, "R4 overlock");
        op(1, 0, 0, 1, 52, 0, 0, "R4 evicted slot");
        op(0, 0, 0, 0, 0, 0, 2'b10, "R5 other clear");
        op(1, 1, 0, 1, 53, 0, 2'b01, "R5 set beats clear");
        op(0, 0, 0, 0, 0, 0, 2'b01, "R5 clear");
        // R2: forwarded and unsupported targets
        op(1, 1, 1, 2, 9, 0, 0, "R2 forward lock");
        op(1, 0, 1, 3, 17, 0, 0, "R2 forward access");
        op(1, 0, 2, 0, 3, 0, 0, "R2 no-op access");
        op(1, 1, 3, 0, 3, 0, 0, "R2 no-op lock");
        op(0, 0, 0, 0, 0, 0, 2'b10, "R5 clear utl");
        op(1, 0, 0, 2, 9, 0, 0, "R2 no local state");
        // R6: flash clear alone, then with a same-cycle lock
        op(0, 0, 0, 0, 0, 1, 0, "R6 flash");
        for (int t = 0; t < 5; t++) op(1, 0, 0, 1, 60 + t, 0, 0, "R6 unlocked after flash");
        for (int t = 0; t < WAYS; t++) op(1, 1, 0, 0, 70 + t, 0, 0, "R6 relock");
        op(1, 1, 0, 0, 80, 1, 0, "R6 flash with lock");
        for (int t = 0; t < WAYS; t++) op(1, 0, 0, 0, 90 + t, 0, 0, "R6 lock survives");
        op(1, 0, 0, 0, 80, 0, 0, "R6 locked line hit");
        // R8: mixed pseudo-random traffic
        for (int i = 0; i < 2000; i++)
            op(rnd(8) != 0, rnd(3) == 0, (rnd(6) == 0) ? 2'(rnd(4)) : 2'd0,
               rnd(SETS), rnd(10), rnd(40) == 0, 2'(rnd(8) == 0 ? rnd(4) : 0), "R8 random");
        summary();
    end
endmodule